// File: doc/BRIEF.md
# Little-Endian Byte-Lane Load/Store Unit

This block sits between a processor core and a data memory that is 32 bits wide and addressed in whole words. On the store side it turns a byte address, a store value and an access size into a word address, a per-byte write-enable mask and write data steered onto the correct byte lanes. On the load side it takes the word returned by memory and produces the register value. For a byte load it picks out the addressed byte and either sign-extends or zero-extends it.

Byte order is little-endian: byte offset 0 is bits 7:0 of the memory word and byte offset 3 is bits 31:24. The core shares one address and one size input between the load and store paths.

A word access whose two low address bits are not zero is flagged as misaligned, and no bytes are written for it. Byte accesses can never be misaligned. The unit is purely combinational, so every output follows its inputs within the same cycle.

Top module: `byte_lane_unit`

## Requirements
- R1: `mem_word_addr` equals `addr` shifted right by two bits (the byte address with bits 1:0 dropped), for every access.
- R2: An aligned word store (`acc_size`=1, `st_req`=1, `addr[1:0]`=00) drives `mem_be`=4'b1111 and `mem_wdata` equal to `st_data`.
- R3: A byte store (`acc_size`=0, `st_req`=1) drives exactly one `mem_be` bit, bit number `addr[1:0]`, where bit 0 enables data bits 7:0.
- R4: When `st_req` is 0, `mem_be` is 4'b0000 whatever the other inputs are.
- R5: A word access (`acc_size`=1) with `addr[1:0]` not 00 raises `misalign` and forces `mem_be` to 0. A byte access never raises `misalign`.
- R6: A word load returns `mem_rdata` unchanged, whether the access is aligned or not.
- R7: A signed byte load (`acc_size`=0, `ld_unsigned`=0) puts byte `addr[1:0]` of `mem_rdata` in result bits 7:0 and copies its bit 7 into bits 31:8. For example, 0xF8 loads as 0xFFFFFFF8.
- R8: An unsigned byte load (`ld_unsigned`=1) puts the selected byte in bits 7:0 and zeroes bits 31:8. For example, 0xF8 loads as 0x000000F8.
- R9: `ld_unsigned` has no effect on a word load.
- R10: A byte store copies `st_data[7:0]` onto all four lanes of `mem_wdata`. Bits 31:8 of `st_data` never reach `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 32 | Byte address of the access |
| acc_size | input | 1 | Access size: 0 = byte, 1 = word |
| st_req | input | 1 | 1 = this access is a store |
| st_data | input | 32 | Register value to store |
| ld_unsigned | input | 1 | 1 = zero-extend byte loads, 0 = sign-extend them |
| mem_rdata | input | 32 | Word read from memory |
| mem_word_addr | output | 30 | Word address sent to memory |
| mem_be | output | 4 | Per-byte write enables, bit i covers data bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-aligned store data |
| ld_result | output | 32 | Value returned to the register file |
| misalign | output | 1 | Word access with nonzero low address bits |

## Verification
The bench replays a store-then-load byte case: the word 0xFFFFF8F5 is stored, and a signed load from offset 1 must return 0xFFFFFFF8. A design with big-endian lane order would return 0xFFFFFFFF, and one that skipped sign extension would return 0xF8.

It sweeps all four byte offsets. An off-by-one or reversed lane decode shows up as the wrong enable bit or the wrong byte. It also stores byte data with nonzero upper bits, so a design that leaked those bits onto the lanes would be caught.

Misaligned word stores must leave every enable low, and a design that still wrote would show a nonzero mask. Word loads with the unsigned flag set and a negative top byte must come back unchanged, so a design that wrongly applied byte extension to words would be exposed.

// File: rtl/lane_unit_pkg.sv
package lane_unit_pkg;

    localparam int unsigned LANE_BITS = 8;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_size_e;

    // one-hot lane select for a given byte offset
    function automatic logic [3:0] lane_onehot(input logic [1:0] off);
        logic [3:0] v;
        v = '0;
        v[off] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/lane_addr_split.sv
module lane_addr_split
    import lane_unit_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 2
) (
    input  logic [ADDR_W-1:0]       addr,
    input  acc_size_e               size,
    output logic [ADDR_W-OFF_W-1:0] word_addr,
    output logic [OFF_W-1:0]        lane_off,
    output logic                    misalign
);
    always_comb begin
        word_addr = addr[ADDR_W-1:OFF_W];
        lane_off  = addr[OFF_W-1:0];
        misalign  = (size == ACC_WORD) && (addr[OFF_W-1:0] != '0);
    end
endmodule

// File: rtl/store_lane_drive.sv
module store_lane_drive
    import lane_unit_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / LANE_BITS,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic              st_req,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  lane_off,
    input  logic              misalign,
    input  logic [DATA_W-1:0] st_data,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    logic [LANES-1:0] byte_sel;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            always_comb begin
                byte_sel[g] = (lane_off == OFF_W'(g));
                if (size == ACC_WORD)
                    wdata[g*LANE_BITS +: LANE_BITS] = st_data[g*LANE_BITS +: LANE_BITS];
                else
                    wdata[g*LANE_BITS +: LANE_BITS] = st_data[LANE_BITS-1:0];
            end
        end
    endgenerate

    always_comb begin
        if (!st_req || misalign)
            be = '0;
        else if (size == ACC_WORD)
            be = '1;
        else
            be = byte_sel;
    end

    always_comb begin
        if (size == ACC_BYTE) begin
            AST_BYTE_ONE_LANE: assert ($onehot0(be)) else $error("byte store enabled several lanes"); // R3
        end
        if (!st_req) begin
            AST_IDLE_NO_WRITE: assert (be == '0) else $error("write enable without store request"); // R4
        end
    end
endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract
    import lane_unit_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / LANE_BITS,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [OFF_W-1:0]  lane_off,
    input  acc_size_e         size,
    input  logic              zero_ext,
    output logic [DATA_W-1:0] result
);
    logic [LANE_BITS-1:0] lanes [LANES];
    logic [LANE_BITS-1:0] picked;
    logic                 fill;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_split
            assign lanes[g] = mem_rdata[g*LANE_BITS +: LANE_BITS];
        end
    endgenerate

    always_comb begin
        picked = lanes[lane_off];
        fill   = !zero_ext && picked[LANE_BITS-1];
        if (size == ACC_WORD)
            result = mem_rdata;
        else
            result = {{(DATA_W-LANE_BITS){fill}}, picked};
    end

    always_comb begin
        if (size == ACC_BYTE) begin
            AST_UPPER_UNIFORM: assert (result[DATA_W-1:LANE_BITS] == '0 || result[DATA_W-1:LANE_BITS] == '1)
                else $error("byte load upper bits not uniform"); // R7
            if (zero_ext) begin
                AST_ZERO_FILL: assert (result[DATA_W-1:LANE_BITS] == '0) else $error("unsigned byte load not zero filled"); // R8
            end
        end
    end
endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
    import lane_unit_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / LANE_BITS,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    acc_size,
    input  logic                    st_req,
    input  logic [DATA_W-1:0]       st_data,
    input  logic                    ld_unsigned,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [ADDR_W-OFF_W-1:0] mem_word_addr,
    output logic [LANES-1:0]        mem_be,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic [DATA_W-1:0]       ld_result,
    output logic                    misalign
);
    acc_size_e        size;
    logic [OFF_W-1:0] lane_off;

    assign size = acc_size_e'(acc_size);

    lane_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_split (
        .addr      (addr),
        .size      (size),
        .word_addr (mem_word_addr),
        .lane_off  (lane_off),
        .misalign  (misalign)
    );

    store_lane_drive #(.DATA_W(DATA_W)) u_store (
        .st_req   (st_req),
        .size     (size),
        .lane_off (lane_off),
        .misalign (misalign),
        .st_data  (st_data),
        .be       (mem_be),
        .wdata    (mem_wdata)
    );

    load_lane_extract #(.DATA_W(DATA_W)) u_load (
        .mem_rdata (mem_rdata),
        .lane_off  (lane_off),
        .size      (size),
        .zero_ext  (ld_unsigned),
        .result    (ld_result)
    );

    always_comb begin
        if (misalign) begin
            AST_MISALIGN_NO_WRITE: assert (mem_be == '0) else $error("misaligned word still writes"); // R5
            AST_MISALIGN_WORD_ONLY: assert (acc_size == 1'b1) else $error("byte access flagged misaligned"); // R5
        end
        if (acc_size == 1'b0 && st_req) begin
            AST_BYTE_LANE_DATA: assert (mem_wdata[LANE_BITS-1:0] == st_data[LANE_BITS-1:0]) else $error("byte lane data wrong"); // R10
        end
    end
endmodule

// File: tb/sim_byte_lane_unit.sv
module sim_byte_lane_unit;
    logic        clk = 1'b0;
    logic [31:0] addr;
    logic        acc_size, st_req, ld_unsigned;
    logic [31:0] st_data, mem_rdata;
    logic [29:0] mem_word_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, ld_result;
    logic        misalign;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    byte_lane_unit u0 (
        .addr(addr), .acc_size(acc_size), .st_req(st_req), .st_data(st_data),
        .ld_unsigned(ld_unsigned), .mem_rdata(mem_rdata),
        .mem_word_addr(mem_word_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .ld_result(ld_result), .misalign(misalign)
    );

    typedef struct packed {
        logic        req;
        logic        sz;
        logic        uns;
        logic [31:0] a;
        logic [31:0] sd;
        logic [31:0] rd;
        logic [3:0]  e_be;
        logic [31:0] e_wd;
        logic [31:0] e_ld;
        logic        e_mis;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b0, 32'h100, 32'hFFFFF8F5, 32'hFFFFF8F5, 4'b1111, 32'hFFFFF8F5, 32'hFFFFF8F5, 1'b0}, // R2 R6
        '{1'b1, 1'b0, 1'b0, 32'h101, 32'h123456AB, 32'hFFFFF8F5, 4'b0010, 32'hABABABAB, 32'hFFFFFFF8, 1'b0}, // R3 R7 R10
        '{1'b0, 1'b0, 1'b1, 32'h101, 32'h000000CD, 32'hFFFFF8F5, 4'b0000, 32'hCDCDCDCD, 32'h000000F8, 1'b0}, // R4 R8
        '{1'b1, 1'b0, 1'b0, 32'h103, 32'h0000007F, 32'h80112233, 4'b1000, 32'h7F7F7F7F, 32'hFFFFFF80, 1'b0}, // R3 R7
        '{1'b1, 1'b0, 1'b0, 32'h200, 32'hFFFFFF55, 32'h0000007F, 4'b0001, 32'h55555555, 32'h0000007F, 1'b0}, // R7 R10
        '{1'b1, 1'b0, 1'b1, 32'h202, 32'h000000AA, 32'h00C30000, 4'b0100, 32'hAAAAAAAA, 32'h000000C3, 1'b0}, // R8
        '{1'b1, 1'b1, 1'b0, 32'h202, 32'h11223344, 32'hDEADBEEF, 4'b0000, 32'h11223344, 32'hDEADBEEF, 1'b1}, // R5 R6
        '{1'b0, 1'b1, 1'b1, 32'h301, 32'h00000000, 32'h80000000, 4'b0000, 32'h00000000, 32'h80000000, 1'b1}, // R5 R9
        '{1'b1, 1'b1, 1'b1, 32'h3FC, 32'hCAFEF00D, 32'hFFFFFF80, 4'b1111, 32'hCAFEF00D, 32'hFFFFFF80, 1'b0}, // R2 R9
        '{1'b1, 1'b1, 1'b0, 32'h303, 32'h01020304, 32'h00000000, 4'b0000, 32'h01020304, 32'h00000000, 1'b1}  // R5
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic s, input logic u, input logic [31:0] a,
                         input logic [31:0] sd, input logic [31:0] rd);
        @(negedge clk);
        st_req = r; acc_size = s; ld_unsigned = u; addr = a; st_data = sd; mem_rdata = rd;
        #2;
    endtask

    initial begin
        #(20 * 5000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // idle state: all inputs zero
        drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0);
        check("R4", "idle be", {28'h0, mem_be}, 32'h0);
        check("R5", "idle misalign", {31'h0, misalign}, 32'h0);
        check("R1", "idle word addr", {2'b0, mem_word_addr}, 32'h0);
        check("R7", "idle load", ld_result, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].req, TBL[i].sz, TBL[i].uns, TBL[i].a, TBL[i].sd, TBL[i].rd);
            check("R1", $sformatf("vec%0d word addr", i), {2'b0, mem_word_addr}, TBL[i].a >> 2);
            check("R3/R4/R5", $sformatf("vec%0d be", i), {28'h0, mem_be}, {28'h0, TBL[i].e_be});
            check("R2/R10", $sformatf("vec%0d wdata", i), mem_wdata, TBL[i].e_wd);
            check("R6/R7/R8", $sformatf("vec%0d load", i), ld_result, TBL[i].e_ld);
            check("R5", $sformatf("vec%0d misalign", i), {31'h0, misalign}, {31'h0, TBL[i].e_mis});
        end

        // byte lane sweep over every offset
        for (int k = 0; k < 4; k++) begin
            logic [31:0] mw;
            mw = 32'h44_83_22_F1;
            drive(1'b1, 1'b0, 1'b0, 32'h0000_0A00 + k, 32'hFFFF_FF00 | (32'h10 + k), mw);
            check("R3", $sformatf("sweep%0d be", k), {28'h0, mem_be}, 32'h1 << k);
            check("R10", $sformatf("sweep%0d wdata", k), mem_wdata, {4{8'h10 + 8'(k)}});
            check("R7", $sformatf("sweep%0d signed", k), ld_result,
                  {{24{mw[8*k+7]}}, mw[8*k +: 8]});
            ld_unsigned = 1'b1; #2;
            check("R8", $sformatf("sweep%0d unsigned", k), ld_result, {24'h0, mw[8*k +: 8]});
        end

        // top address bits drop correctly
        drive(1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, 32'h0);
        check("R1", "max addr", {2'b0, mem_word_addr}, 32'h3FFF_FFFF);
        check("R5", "byte at odd addr no misalign", {31'h0, misalign}, 32'h0);

        // store then load: word 0xFFFFF8F5, signed byte at +1
        drive(1'b1, 1'b1, 1'b0, 32'h40, 32'hFFFFF8F5, 32'h0);
        check("R2", "word store be", {28'h0, mem_be}, 32'hF);
        drive(1'b0, 1'b0, 1'b0, 32'h41, 32'h0, mem_wdata);
        check("R7", "store-load byte", ld_result, 32'hFFFFFFF8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule